// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block produces the external bus timing for an 8-bit processor with a 16-bit address space. The upper address byte has its own output pins. The lower address byte and the data byte share one bidirectional bus. The block steps through clock-period T-states for five kinds of machine cycle: opcode fetch, memory read, memory write, port read and port write. For each cycle it drives an address strobe, a port-or-memory select, two status bits, and active-low read and write strobes.

A core asks for a cycle by pulsing `start` while the sequencer is idle. The request carries the cycle kind, the full address and any write data. The block runs the cycle on the pins. When the cycle ends, it returns the captured byte on `rdata` together with a one-cycle `done` pulse. A byte read by a fetch is the opcode, and a byte read by a memory or port read is the data.

On the shared bus, the low address byte appears only during the first T-state. A transparent latch inside the block follows the bus while the address strobe is high and holds that byte afterwards. The latch output is brought out as the demultiplexed low address.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset the outputs are in their idle state: `ale`=0, `rd_n`=1, `wr_n`=1, `done`=0, and {`io_m`,`s1`,`s0`}=000.
- R2: `ale` is high for exactly the first T-state (T1) of each cycle, which is the clock period after the accepting edge. During T1 the shared bus carries `addr[7:0]`.
- R3: `addr_hi` equals `addr[15:8]` of the accepted request throughout T1, T2 and T3.
- R4: From T1 onward, {`io_m`,`s1`,`s0`} shows the cycle kind. The kinds are `kind` 0 = fetch (011), 1 = memory read (010), 2 = memory write (001), 3 = port read (110) and 4 = port write (101). The status holds its value after the cycle until the next cycle is accepted.
- R5: `rd_n` is low only during T2 and T3 of kinds 0, 1 and 3. `wr_n` is low only during T2 and T3 of kinds 2 and 4. The two strobes are never low together.
- R6: During T2 and T3 of a write kind, the shared bus carries the request's write data.
- R7: On read kinds the shared bus is sampled on the clock edge that ends T3. That byte appears on `rdata` while `done` is high.
- R8: A fetch lasts four T-states and every other kind lasts three. `done` is high for exactly the one clock period that follows the last T-state.
- R9: `lat_lo` follows the shared bus while `ale` is high. It holds `addr[7:0]` through T2 and T3 while the bus carries data.
- R10: A `start` that arrives while a cycle is in progress is ignored, and so is a `start` with `kind` 5, 6 or 7. Neither one begins a cycle or produces `done`.
- R11: The block releases the shared bus during T4 of a fetch and while `rd_n` is low, so that an external source can drive it without contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a cycle; taken only when idle |
| kind | input | 3 | Cycle kind, encoded as in R4 |
| addr | input | 16 | Full cycle address |
| wdata | input | 8 | Data for write kinds |
| done | output | 1 | One-cycle pulse after the last T-state |
| rdata | output | 8 | Byte captured at the end of T3 on read kinds |
| addr_hi | output | 8 | Upper address byte pins |
| ad_bus | inout | 8 | Shared low-address / data bus |
| ale | output | 1 | Address strobe, high in T1 |
| io_m | output | 1 | 1 = port cycle, 0 = memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| lat_lo | output | 8 | Demultiplexed low address from the internal latch |

## Verification
A wrong T-state shows on the pins within one clock period. `ale` would pulse outside the first period, a strobe would fall a period early or late, or `done` would arrive after the wrong count of periods. Each of these is checked at every T-state of every cycle. A stale captured request shows in the same cycle as a wrong status code, a wrong upper address byte or wrong write data on the shared bus. A lost capture only shows when `done` rises, as a wrong `rdata`. Every kind is swept over a dozen addresses. Fetches and operand reads are run back to back at consecutive addresses, and requests made while busy or with an undefined kind are checked for having no effect on later pin activity.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } cyc_kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  // {io_m, s1, s0}
  function automatic logic [2:0] status_of(input logic [2:0] k);
    case (k)
      3'd0:    return 3'b011;
      3'd1:    return 3'b010;
      3'd2:    return 3'b001;
      3'd3:    return 3'b110;
      3'd4:    return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic is_rd(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
  endfunction

  function automatic logic is_wr(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction

endpackage

// File: rtl/mbus_tseq.sv
module mbus_tseq
  import mbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    kind,
  output tstate_e       st_q,
  output tstate_e       st_d,
  output logic          accept,
  output logic          done
);

  logic [2:0] kind_q;

  assign accept = (st_q == TS_IDLE) && start && kind_ok(kind);

  always_comb begin
    st_d = st_q;
    case (st_q)
      TS_IDLE: if (accept) st_d = TS_T1;
      TS_T1:   st_d = TS_T2;
      TS_T2:   st_d = TS_T3;
      TS_T3:   st_d = (kind_q == K_FETCH) ? TS_T4 : TS_IDLE;
      TS_T4:   st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TS_IDLE;
      kind_q <= 3'd0;
      done   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) kind_q <= kind;
      done <= (st_q != TS_IDLE) && (st_d == TS_IDLE);
    end
  end

  // R8: completion pulse lasts one period
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: no new cycle begins while one is running
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (st_q == TS_T2) |=> (st_q == TS_T3));

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  tstate_e       st_q,
  input  tstate_e       st_d,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic          io_m,
  output logic          s1,
  output logic          s0,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata
);

  localparam int HW = AW - DW;

  logic [2:0]    k_q;
  logic [DW-1:0] w_q;
  logic          strobe_d;

  assign strobe_d = (st_d == TS_T2) || (st_d == TS_T3);

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q     <= 3'd0;
      w_q     <= '0;
      addr_hi <= '0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      ale     <= 1'b0;
      io_m    <= 1'b0;
      s1      <= 1'b0;
      s0      <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      rdata   <= '0;
    end else begin
      ale <= (st_d == TS_T1);
      if (accept) begin
        k_q              <= kind;
        w_q              <= wdata;
        {io_m, s1, s0}   <= status_of(kind);
        addr_hi          <= addr[AW-1:DW];
        ad_out           <= addr[DW-1:0];
        ad_oe            <= 1'b1;
        rd_n             <= 1'b1;
        wr_n             <= 1'b1;
      end else begin
        ad_out <= w_q;
        ad_oe  <= strobe_d && is_wr(k_q);
        rd_n   <= !(strobe_d && is_rd(k_q));
        wr_n   <= !(strobe_d && is_wr(k_q));
      end
      if ((st_q == TS_T3) && is_rd(k_q)) rdata <= ad_in;
    end
  end

  // R5: the two strobes never overlap
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R5: a strobe is never low in T1
  a_r5_no_strobe_t1: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n));

  logic unused_hw;
  assign unused_hw = (HW > 0);

endmodule

// File: rtl/mbus_lo_latch.sv
module mbus_lo_latch #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_latch begin
    if (en) q <= d;
  end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       kind,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic [AW-DW-1:0] addr_hi,
  inout  wire  [DW-1:0]    ad_bus,
  output logic             ale,
  output logic             io_m,
  output logic             s1,
  output logic             s0,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    lat_lo
);

  tstate_e       st_q, st_d;
  logic          accept;
  logic [DW-1:0] ad_out;
  logic          ad_oe;

  mbus_tseq u_tseq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .kind   (kind),
    .st_q   (st_q),
    .st_d   (st_d),
    .accept (accept),
    .done   (done)
  );

  mbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .st_q    (st_q),
    .st_d    (st_d),
    .kind    (kind),
    .addr    (addr),
    .wdata   (wdata),
    .ad_in   (ad_bus),
    .addr_hi (addr_hi),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .io_m    (io_m),
    .s1      (s1),
    .s0      (s0),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .rdata   (rdata)
  );

  assign ad_bus = ad_oe ? ad_out : {DW{1'bz}};

  mbus_lo_latch #(.W(DW)) u_lat (
    .en (ale),
    .d  (ad_bus),
    .q  (lat_lo)
  );

  // R2: address strobe only in the first T-state
  a_r2_ale_only_t1: assert property (@(posedge clk) disable iff (rst)
    ale |-> (st_q == TS_T1));

  // R3: upper address byte steady across T2 and T3
  a_r3_hi_stable: assert property (@(posedge clk) disable iff (rst)
    ((st_q == TS_T2) || (st_q == TS_T3)) |-> $stable(addr_hi));

  // R9: latched low address held while data occupies the bus
  a_r9_latch_hold: assert property (@(posedge clk) disable iff (rst)
    ((st_q == TS_T2) || (st_q == TS_T3)) |-> $stable(lat_lo));

  // R11: bus released while reading and in T4
  a_r11_released: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || (st_q == TS_T4)) |-> !ad_oe);

endmodule

// File: tb/tb_mbus_cycle_seq.sv
`timescale 1ns/1ps
module tb_mbus_cycle_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        done;
  logic [7:0]  rdata;
  logic [7:0]  addr_hi;
  wire  [7:0]  ad_bus;
  logic        ale, io_m, s1, s0, rd_n, wr_n;
  logic [7:0]  lat_lo;

  logic [7:0]  mem_q = '0;
  logic        t4_drv = 1'b0;
  int          tests = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  assign ad_bus = !rd_n ? mem_q : (t4_drv ? 8'hC3 : 8'bz);

  mbus_cycle_seq dut (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .addr(addr),
    .wdata(wdata), .done(done), .rdata(rdata), .addr_hi(addr_hi),
    .ad_bus(ad_bus), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0),
    .rd_n(rd_n), .wr_n(wr_n), .lat_lo(lat_lo)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_status(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [7:0] mem_of(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] w, input bit poke);
    logic rdk, wrk;
    rdk = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    wrk = (k == 3'd2) || (k == 3'd4);
    @(negedge clk);
    start = 1'b1; kind = k; addr = a; wdata = w; mem_q = mem_of(a);
    @(negedge clk);
    start = 1'b0;
    chk("R2 ale in T1", 16'(ale), 16'd1);
    chk("R2 low address on bus", 16'(ad_bus), 16'(a[7:0]));
    chk("R3 high address T1", 16'(addr_hi), 16'(a[15:8]));
    chk("R4 status", 16'({io_m, s1, s0}), 16'(exp_status(k)));
    chk("R5 strobes high in T1", 16'({rd_n, wr_n}), 16'b11);
    chk("R9 latch follows", 16'(lat_lo), 16'(a[7:0]));
    if (poke) begin
      start = 1'b1; kind = 3'd2; addr = ~a;
    end
    for (int t = 2; t <= 3; t++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R2 ale low after T1", 16'(ale), 16'd0);
      chk("R3 high address", 16'(addr_hi), 16'(a[15:8]));
      chk("R5 strobes", 16'({rd_n, wr_n}), 16'({!rdk, !wrk}));
      if (wrk) chk("R6 write data", 16'(ad_bus), 16'(w));
      chk("R9 latch holds", 16'(lat_lo), 16'(a[7:0]));
      chk("R8 no early done", 16'(done), 16'd0);
    end
    if (k == 3'd0) begin
      @(negedge clk);
      t4_drv = 1'b1;
      #1;
      chk("R11 bus free in T4", 16'(ad_bus), 16'h00C3);
      chk("R5 strobes high in T4", 16'({rd_n, wr_n}), 16'b11);
      chk("R8 fetch has T4", 16'(done), 16'd0);
      t4_drv = 1'b0;
    end
    @(negedge clk);
    chk("R8 done after last T-state", 16'(done), 16'd1);
    if (rdk) chk("R7 read data", 16'(rdata), 16'(mem_of(a)));
    chk("R4 status held", 16'({io_m, s1, s0}), 16'(exp_status(k)));
    @(negedge clk);
    chk("R8 done single", 16'(done), 16'd0);
    chk("R10 no extra cycle", 16'(ale), 16'd0);
    chk("R4 status still held", 16'({io_m, s1, s0}), 16'(exp_status(k)));
  endtask

  task automatic bad_kind(input logic [2:0] k);
    @(negedge clk);
    start = 1'b1; kind = k; addr = 16'hBEEF;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk("R10 undefined kind ignored", 16'({ale, done, rd_n, wr_n}), 16'b0011);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset ale", 16'(ale), 16'd0);
    chk("R1 reset strobes", 16'({rd_n, wr_n}), 16'b11);
    chk("R1 reset done", 16'(done), 16'd0);
    chk("R1 reset status", 16'({io_m, s1, s0}), 16'd0);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 12; i++) begin
        logic [15:0] a;
        a = 16'(i * 16'h1111 + k * 16'h0307) ^ (i[0] ? 16'hFF00 : 16'h0000);
        run_cycle(3'(k), a, 8'(i * 37 + k), i == 3);
      end
    end
    for (int i = 0; i < 4; i++) begin
      run_cycle(3'd0, 16'h2000 + 16'(i * 2), 8'h00, 1'b0);
      run_cycle(3'd1, 16'h2001 + 16'(i * 2), 8'h00, 1'b0);
    end
    run_cycle(3'd0, 16'hFFFF, 8'h00, 1'b0);
    run_cycle(3'd2, 16'h0000, 8'hFF, 1'b0);
    bad_kind(3'd5);
    bad_kind(3'd6);
    bad_kind(3'd7);
    run_cycle(3'd3, 16'h00FE, 8'h00, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule